// File: doc/BRIEF.md
# Interleaved Four-Bank Word Memory Front End

This block sits in front of four independent read-only memory banks and hands each incoming word read to the bank chosen by the low bits of its word address. Every bank is busy for a fixed number of clocks after it takes an access. It returns its word a shorter, fixed number of clocks after the access starts. Because neighbouring word addresses land in neighbouring banks, a stream of ascending addresses can start a new access every clock while earlier banks are still working. An address that hits a bank still inside its busy window is held off until that bank frees.

Requests arrive on a valid/ready port carrying a word address. Results leave on a response port with a data bus and a one-cycle valid flag, with no backpressure. A small queue of bank indices, filled in acceptance order, makes sure words leave in the order their requests were accepted, even though the even-numbered banks take longer than the odd-numbered ones. The banks are behavioural models whose contents are a fixed function of the address.

Top module: `ilv_mem_ctrl`

## Requirements
- R1: The bank serving a request is the request's word address modulo 4, taken from address bits [1:0]. Two addresses that differ only above bit 1 compete for the same bank.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low while the addressed bank has accepted an access within the last BANK_CYC (default 4) edges.
- R3: Requests to different banks may be accepted on consecutive edges, whatever bank the run starts on. Four requests to four distinct free banks are accepted in four consecutive cycles.
- R4: A run of ascending word addresses presented every cycle is accepted at one per clock. Its responses appear on consecutive cycles once the first arrives.
- R5: The data returned for word address A is {A[15:0] XOR 16'hA5C3, bitwise NOT of A[15:0]} (upper half, lower half).
- R6: Responses leave in acceptance order. A bank with an even index delivers its word ACC_LAT+ACC_SKEW (default 3) edges after acceptance, and an odd-index bank delivers it ACC_LAT (default 1) edges after acceptance.
- R7: The response for a request accepted at edge E appears, valid for exactly one cycle, at edge max(E + bank latency + 1, previous response edge + 1).
- R8: After reset `rsp_valid` is low, nothing is outstanding, and every bank is free, so `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Word address of the request |
| req_ready | output | 1 | Request can be accepted this cycle |
| rsp_valid | output | 1 | Response word valid this cycle |
| rsp_data | output | DATA_W | Response word |

## Verification
The delicate case is a bank that starts a new access on the very edge its previous word leaves through the response port. In the same cycle, the index queue is pushed and popped. An ascending stream starting at a multiple of four provokes both every fourth clock, because the slow bank 0 is released exactly when its earlier word is delivered. A behavioural model in the bench predicts the ready level and the exact response edge and data for every cycle. Any lost, duplicated or early word therefore shows up as a mismatch on that cycle.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  // Behavioural bank contents: a fixed function of the word address.
  function automatic logic [31:0] bank_word(input logic [31:0] a);
    return {a[15:0] ^ 16'hA5C3, ~a[15:0]};
  endfunction

  // Access time of bank b: even banks are the slower ones.
  function automatic int bank_lat(input int b, input int base, input int skew);
    return (b % 2 == 0) ? base + skew : base;
  endfunction

endpackage

// File: rtl/ilv_bank.sv
module ilv_bank
  import ilv_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int BANK_CYC = 4,
  parameter int LAT      = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              take_i,
  output logic              free_o,
  output logic              held_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int BW = $clog2(BANK_CYC + 1);
  localparam int LW = $clog2(LAT + 1);

  logic [BW-1:0]     busy_q, busy_d;
  logic [LW-1:0]     lcnt_q, lcnt_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              held_q, held_d;
  logic [DATA_W-1:0] data_q, data_d;

  always_comb begin
    busy_d = busy_q;
    lcnt_d = lcnt_q;
    addr_d = addr_q;
    held_d = held_q;
    data_d = data_q;
    if (acc_i) begin
      busy_d = BW'(BANK_CYC - 1);
      lcnt_d = LW'(LAT);
      addr_d = addr_i;
    end else begin
      if (busy_q != '0) busy_d = busy_q - 1'b1;
      if (lcnt_q != '0) lcnt_d = lcnt_q - 1'b1;
    end
    if (take_i) held_d = 1'b0;
    if (lcnt_q == LW'(1)) begin
      held_d = 1'b1;
      data_d = DATA_W'(bank_word(32'(addr_q)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
      lcnt_q <= '0;
      addr_q <= '0;
      held_q <= 1'b0;
      data_q <= '0;
    end else begin
      busy_q <= busy_d;
      lcnt_q <= lcnt_d;
      addr_q <= addr_d;
      held_q <= held_d;
      data_q <= data_d;
    end
  end

  assign free_o = (busy_q == '0);
  assign held_o = held_q;
  assign data_o = data_q;

  // R2: a new access only lands on a bank whose busy window has run out
  assert_free_on_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_i |-> (busy_q == '0));

  // R6: a finishing access never overwrites a word still waiting to leave
  assert_no_clobber_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lcnt_q == LW'(1)) |-> (!held_q || take_i));

endmodule

// File: rtl/ilv_tagq.sv
module ilv_tagq #(
  parameter int W     = 2,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push_i) wr_d = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (pop_i)  rd_d = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    case ({push_i, pop_i})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) mem_q[wr_q] <= din_i;
  end

  assign dout_o  = mem_q[rd_q];
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);

  // R6: order is kept only if no index is ever dropped
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !full_o);

  // R7: a response is only released for a request that is outstanding
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o);

endmodule

// File: rtl/ilv_mem_ctrl.sv
module ilv_mem_ctrl
  import ilv_pkg::*;
#(
  parameter int NB       = 4,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int BANK_CYC = 4,
  parameter int ACC_LAT  = 1,
  parameter int ACC_SKEW = 2,
  parameter int QDEPTH   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  localparam int BB = $clog2(NB);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  logic [BB-1:0]     sel, head;
  logic [NB-1:0]     free, held, acc, take;
  logic [DATA_W-1:0] bdata [NB];
  logic              fire, pop, q_full, q_empty;

  assign sel       = req_addr[BB-1:0];
  assign req_ready = free[sel] && !q_full;
  assign fire      = req_valid && req_ready;
  assign pop       = !q_empty && held[head];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign acc[b]  = fire && (sel == BB'(b));
    assign take[b] = pop && (head == BB'(b));
    ilv_bank #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .BANK_CYC (BANK_CYC),
      .LAT      (bank_lat(b, ACC_LAT, ACC_SKEW))
    ) u_bank (
      .clk    (clk),
      .rst_n  (rst_i),
      .acc_i  (acc[b]),
      .addr_i (req_addr),
      .take_i (take[b]),
      .free_o (free[b]),
      .held_o (held[b]),
      .data_o (bdata[b])
    );
  end

  ilv_tagq #(
    .W     (BB),
    .DEPTH (QDEPTH)
  ) u_tagq (
    .clk     (clk),
    .rst_n   (rst_i),
    .push_i  (fire),
    .din_i   (sel),
    .pop_i   (pop),
    .dout_o  (head),
    .full_o  (q_full),
    .empty_o (q_empty)
  );

  logic              vld_q, vld_d;
  logic [DATA_W-1:0] dat_q, dat_d;

  always_comb begin
    vld_d = pop;
    dat_d = dat_q;
    if (pop) dat_d = bdata[head];
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      vld_q <= vld_d;
      dat_q <= dat_d;
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_data  = dat_q;

endmodule

// File: tb/ilv_mem_ctrl_tb.sv
module ilv_mem_ctrl_tb;
  localparam int NB = 4, ADDR_W = 12, DATA_W = 32, BANK_CYC = 4;
  localparam int ACC_LAT = 1, ACC_SKEW = 2, QDEPTH = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid;
  logic [ADDR_W-1:0] req_addr;
  logic              req_ready, rsp_valid;
  logic [DATA_W-1:0] rsp_data;

  always #2 clk = ~clk;

  ilv_mem_ctrl #(
    .NB(NB), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_CYC(BANK_CYC),
    .ACC_LAT(ACC_LAT), .ACC_SKEW(ACC_SKEW), .QDEPTH(QDEPTH)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // reference model state
  int last_acc [NB];
  int qa[$];
  int qd[$];
  int last_due = -1000;
  int nchk = 0, nbad = 0;
  bit acc_last;
  int rsp_seen, rsp_first, rsp_last;

  function automatic logic [31:0] exp_word(int a);
    logic [31:0] hi, lo;
    hi = (a ^ 32'hA5C3) & 32'hFFFF;
    lo = (~a) & 32'hFFFF;
    return (hi << 16) | lo;
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%0h exp=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic step(bit v, int a);
    int  b, e, lat, due;
    bit  ev, er;
    @(negedge clk);
    // R6 R7: response expected at the edge just passed
    ev = (qd.size() > 0) && (qd[0] == cyc);
    check(rsp_valid === ev, "R6 R7 rsp_valid", rsp_valid, ev);
    if (ev) begin
      check(rsp_data === exp_word(qa[0]), "R5 rsp_data", rsp_data, exp_word(qa[0]));
      void'(qa.pop_front());
      void'(qd.pop_front());
    end
    if (rsp_valid) begin
      rsp_seen++;
      if (rsp_first < 0) rsp_first = cyc;
      rsp_last = cyc;
    end
    req_valid = v;
    req_addr  = ADDR_W'(a);
    #1;
    b  = a % NB;
    e  = cyc + 1;
    er = ((e - last_acc[b]) >= BANK_CYC) && (qd.size() < QDEPTH);
    check(req_ready === er, "R1 R2 req_ready", req_ready, er);
    acc_last = v && er;
    if (acc_last) begin
      lat = (b % 2 == 0) ? ACC_LAT + ACC_SKEW : ACC_LAT;
      due = e + lat + 1;
      if (due < last_due + 1) due = last_due + 1;
      last_due = due;
      last_acc[b] = e;
      qa.push_back(a);
      qd.push_back(due);
    end
  endtask

  task automatic send(int a, output int n);
    n = 0;
    do begin
      step(1'b1, a);
      n++;
    end while (!acc_last);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 0);
  endtask

  initial begin : watchdog
    #(4 * 50000);
    nchk++;
    nbad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin : main
    int n, tot, accs;
    for (int i = 0; i < NB; i++) last_acc[i] = -1000;
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R8: reset state
    check(rsp_valid === 1'b0, "R8 rsp_valid after reset", rsp_valid, 0);
    check(req_ready === 1'b1, "R8 req_ready after reset", req_ready, 1);
    idle(2);

    // R4: ascending run from a multiple of four
    rsp_seen = 0; rsp_first = -1; rsp_last = -1; accs = 0;
    for (int i = 0; i < 32; i++) begin
      step(1'b1, i);
      if (acc_last) accs++;
    end
    idle(10);
    check(accs == 32, "R4 accepts in sequential run", accs, 32);
    check(rsp_seen == 32, "R4 responses in sequential run", rsp_seen, 32);
    check(rsp_last - rsp_first == 31, "R4 response spacing", rsp_last - rsp_first, 31);

    // R3: four distinct banks, run starting on bank 1
    accs = 0;
    for (int i = 5; i < 9; i++) begin
      step(1'b1, i);
      if (acc_last) accs++;
    end
    check(accs == 4, "R3 back-to-back distinct banks", accs, 4);
    idle(8);

    // R1 R2: same bank repeatedly (addresses differ above bit 1)
    tot = 0;
    for (int k = 0; k < 4; k++) begin
      send(k * 4 + 2, n);
      tot += n;
    end
    check(tot == 1 + 3 * BANK_CYC, "R1 R2 same-bank stall cycles", tot, 1 + 3 * BANK_CYC);
    idle(8);

    // mixed traffic with gaps
    for (int i = 0; i < 120; i++) begin
      send(int'($urandom_range(63)), n);
      idle(int'($urandom_range(2)));
    end
    // ascending runs at every bank offset
    for (int s = 0; s < NB; s++) begin
      for (int i = 0; i < 12; i++) send(100 + s + i, n);
      idle(3);
    end
    idle(12);
    check(qd.size() == 0, "R6 all responses delivered", qd.size(), 0);

    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

endmodule